// File: doc/BRIEF.md
# Register Snapshot Storage Sequencer

This block saves chosen groups of a sparse byte-wide register space into an internal non-volatile byte store, and later restores them. A short script in a dedicated buffer names what to save. Each script byte is either the first byte of a three-byte group descriptor (a byte count, then a 16-bit start address) or a one-byte operation code. A store pass walks the script and writes each descriptor and its register contents into the store. It closes with an end code and a checksum. A restore pass walks the store the same way, puts the saved bytes back into the staged registers, and verifies the checksum.

Staged registers only reach the active register space when the restore meets an update code. A pseudo-end code lets software build one image over several store passes. Each pass appends to the previous one, with a different script and register contents each time. A later restore runs through every pseudo-end up to the real end. A busy flag and a data-error flag are available both as pins and as readable registers.

Top module: `snapshot_seq`

## Requirements
- R1: After reset, busy and dataError are 0. The store-enable bit reads 0, and every staged register, active register and script byte reads 0x00.
- R2: Address map. Staged registers are read/write at 0x0000 to 0x003F. Active registers read back, read-only, at 0x0100 to 0x013F. The script buffer is read/write at 0x0A00 to 0x0A1F. Status: 0x0B00 bit 0 is busy, 0x0B01 bit 0 is the error flag, 0x0B02 bit 0 is the read/write store enable. Command register 0x0B03: bit 0 starts a store and bit 1 starts a restore; it clears itself and always reads 0x00. Unmapped addresses read 0x00.
- R3: A store command takes effect only while the store enable is 1 and the block is idle; otherwise it is ignored and busy stays 0. An accepted command raises busy on the clock edge that takes the write.
- R4: A script byte with bit 7 clear opens a group descriptor. Its bits [6:0] hold the number of registers minus one, and the next two bytes give the start address, high byte first. That many consecutive registers are copied, and registers outside the group are left untouched.
- R5: End code 0xFF ends a store. The store writes 0xFF, then a checksum byte: the modulo-256 sum of every stored byte from the start of the store up to and including the 0xFF. On a restore, 0xFF makes the block read that checksum and end the pass.
- R6: On a restore, a checksum that differs from the recomputed sum sets dataError to 1. Any new pass clears dataError when it starts.
- R7: Update code 0x80, met during a restore, copies all staged registers to the active registers at once. The active registers change at no other time, so values restored without an update code never reach them.
- R8: Pseudo-end code 0xFE, met during a store, is stored and ends the pass without a checksum. The next store appends after it and keeps the running checksum. A restore steps over 0xFE and continues to the real end. A restore discards any pending append, so the store after it starts from the beginning of the store.
- R9: If a pass needs a store location beyond the last one, it ends at once with dataError set.
- R10: Host writes to the staged registers, the script buffer and the enable bit are ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 16 | Host register address |
| regWrEn | input | 1 | Host write strobe for regWrData at regAddr |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Combinational read data at regAddr |
| busy | output | 1 | High while a store or restore pass runs |
| dataError | output | 1 | Checksum mismatch or store exhausted in the last pass |

## Verification
The bench builds an image over two passes, using a pseudo-end followed by an append. A design that restarted the store or the checksum on the second pass would lose the first group or report a false error. A second case shortens an older image by overwriting its update code with a pseudo-end. Because the restore then runs into the older tail, this case checks both that the restore continues past 0xFE and that the checksum mismatch is flagged. Further checks target these faults: active registers that follow a restore with no update code, a count field read as the byte count rather than the count minus one (a neighbour register would be overwritten), a store started without the enable, a group too large for the store that would otherwise write past its end, and host writes that slip in during a pass.

// File: rtl/snapshot_seq_pkg.sv
package snapshot_seq_pkg;

  localparam logic [15:0] ACTIVE_BASE = 16'h0100;
  localparam logic [15:0] SCRIPT_BASE = 16'h0A00;
  localparam logic [15:0] STATUS_ADDR = 16'h0B00;
  localparam logic [15:0] ERROR_ADDR  = 16'h0B01;
  localparam logic [15:0] ENABLE_ADDR = 16'h0B02;
  localparam logic [15:0] CMD_ADDR    = 16'h0B03;

  localparam logic [7:0] OP_END    = 8'hFF;
  localparam logic [7:0] OP_PSEUDO = 8'hFE;
  localparam logic [7:0] OP_UPDATE = 8'h80;

  typedef enum logic [1:0] {
    SRC_SCRIPT,
    SRC_REG,
    SRC_SUM
  } srcSel_e;

  typedef struct packed {
    logic    startStore;
    logic    startRestore;
    logic    memWrite;
    logic    memRead;
    srcSel_e wrSel;
    logic    scriptAdv;
    logic    latchCnt;
    logic    latchHi;
    logic    latchLo;
    logic    grpStep;
    logic    stageWrite;
    logic    applyUpdate;
    logic    markAppend;
    logic    clrAppend;
    logic    setErr;
    logic    checkSum;
  } strobe_t;

  typedef struct packed {
    logic [7:0] curByte;
    logic       cntZero;
    logic       memFull;
    logic       cmdStore;
    logic       cmdRestore;
    logic       storeEn;
  } status_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_S_OP,
    ST_S_HI,
    ST_S_LO,
    ST_S_DAT,
    ST_S_SUM,
    ST_R_OP,
    ST_R_HI,
    ST_R_LO,
    ST_R_DAT,
    ST_R_SUM
  } state_e;

endpackage

// File: rtl/snapshot_seq_dp.sv
module snapshot_seq_dp
  import snapshot_seq_pkg::*;
#(
  parameter int REG_DEPTH    = 64,
  parameter int SCRIPT_DEPTH = 32,
  parameter int STORE_DEPTH  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        busy,
  input  strobe_t     strb,
  output status_t     stat,
  output logic        dataError
);

  localparam int RA_W = $clog2(REG_DEPTH);
  localparam int SA_W = $clog2(SCRIPT_DEPTH);
  localparam int SP_W = SA_W + 1;
  localparam int MP_W = $clog2(STORE_DEPTH) + 1;
  localparam logic [15:0]     REG_SIZE16 = 16'(REG_DEPTH);
  localparam logic [15:0]     SCR_SIZE16 = 16'(SCRIPT_DEPTH);
  localparam logic [SP_W-1:0] SCR_LIMIT  = SP_W'(SCRIPT_DEPTH);
  localparam logic [MP_W-1:0] MEM_LIMIT  = MP_W'(STORE_DEPTH);

  logic [REG_DEPTH-1:0][7:0]    stagedQ;
  logic [REG_DEPTH-1:0][7:0]    activeQ;
  logic [SCRIPT_DEPTH-1:0][7:0] scriptQ;
  logic [7:0]                   storeMem [STORE_DEPTH];

  logic            enableQ, errQ, appendQ, dirStoreQ;
  logic [SP_W-1:0] scriptPtr;
  logic [MP_W-1:0] memPtr;
  logic [7:0]      sumQ;
  logic [15:0]     grpAddr;
  logic [6:0]      grpCnt;

  // host address decode
  logic [15:0]     scrOff, actOff;
  logic            inStaged, inScript, inActive, hostWr;
  logic [RA_W-1:0] regIdx, actIdx, grpIdx;
  logic [SA_W-1:0] scrIdx;

  assign hostWr   = regWrEn && !busy;
  assign scrOff   = regAddr - SCRIPT_BASE;
  assign actOff   = regAddr - ACTIVE_BASE;
  assign inStaged = regAddr < REG_SIZE16;
  assign inScript = (regAddr >= SCRIPT_BASE) && (scrOff < SCR_SIZE16);
  assign inActive = (regAddr >= ACTIVE_BASE) && (actOff < REG_SIZE16);
  assign regIdx   = regAddr[RA_W-1:0];
  assign actIdx   = actOff[RA_W-1:0];
  assign scrIdx   = scrOff[SA_W-1:0];

  // sequencer-side byte sources
  logic [7:0] scriptByte, memByte, grpRegByte, wrByte;
  logic       memFull, grpInRange;

  assign scriptByte = (scriptPtr < SCR_LIMIT) ? scriptQ[scriptPtr[SP_W-2:0]] : OP_END;
  assign memFull    = (memPtr == MEM_LIMIT);
  assign memByte    = storeMem[memPtr[MP_W-2:0]];
  assign grpInRange = grpAddr < REG_SIZE16;
  assign grpIdx     = grpAddr[RA_W-1:0];
  assign grpRegByte = grpInRange ? stagedQ[grpIdx] : 8'h00;

  always_comb begin
    case (strb.wrSel)
      SRC_REG: wrByte = grpRegByte;
      SRC_SUM: wrByte = sumQ;
      default: wrByte = scriptByte;
    endcase
  end

  assign stat.curByte    = dirStoreQ ? scriptByte : memByte;
  assign stat.cntZero    = (grpCnt == 7'd0);
  assign stat.memFull    = memFull;
  assign stat.cmdStore   = regWrEn && !busy && (regAddr == CMD_ADDR) && regWrData[0];
  assign stat.cmdRestore = regWrEn && !busy && (regAddr == CMD_ADDR) && regWrData[1];
  assign stat.storeEn    = enableQ;
  assign dataError       = errQ;

  always_comb begin
    regRdData = 8'h00;
    if (inStaged)                    regRdData = stagedQ[regIdx];
    else if (inActive)               regRdData = activeQ[actIdx];
    else if (inScript)               regRdData = scriptQ[scrIdx];
    else if (regAddr == STATUS_ADDR) regRdData = {7'd0, busy};
    else if (regAddr == ERROR_ADDR)  regRdData = {7'd0, errQ};
    else if (regAddr == ENABLE_ADDR) regRdData = {7'd0, enableQ};
  end

  // the modelled non-volatile array is not cleared by reset
  always_ff @(posedge clk) begin
    if (strb.memWrite && !memFull) storeMem[memPtr[MP_W-2:0]] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedQ   <= '0;
      activeQ   <= '0;
      scriptQ   <= '0;
      enableQ   <= 1'b0;
      errQ      <= 1'b0;
      appendQ   <= 1'b0;
      dirStoreQ <= 1'b0;
      scriptPtr <= '0;
      memPtr    <= '0;
      sumQ      <= '0;
      grpAddr   <= '0;
      grpCnt    <= '0;
    end else begin
      if (hostWr && inStaged) stagedQ[regIdx] <= regWrData;
      if (hostWr && inScript) scriptQ[scrIdx] <= regWrData;
      if (hostWr && regAddr == ENABLE_ADDR) enableQ <= regWrData[0];

      if (strb.startStore) begin
        dirStoreQ <= 1'b1;
        scriptPtr <= '0;
        errQ      <= 1'b0;
        if (!appendQ) begin
          memPtr <= '0;
          sumQ   <= '0;
        end
      end
      if (strb.startRestore) begin
        dirStoreQ <= 1'b0;
        scriptPtr <= '0;
        errQ      <= 1'b0;
        memPtr    <= '0;
        sumQ      <= '0;
        appendQ   <= 1'b0;
      end

      if (strb.scriptAdv && scriptPtr != SCR_LIMIT) scriptPtr <= scriptPtr + 1'b1;
      if (strb.memWrite) begin
        memPtr <= memPtr + 1'b1;
        sumQ   <= sumQ + wrByte;
      end
      if (strb.memRead) begin
        memPtr <= memPtr + 1'b1;
        sumQ   <= sumQ + memByte;
      end

      if (strb.latchCnt) grpCnt <= stat.curByte[6:0];
      if (strb.latchHi)  grpAddr[15:8] <= stat.curByte;
      if (strb.latchLo)  grpAddr[7:0]  <= stat.curByte;
      if (strb.grpStep) begin
        grpAddr <= grpAddr + 16'd1;
        if (!stat.cntZero) grpCnt <= grpCnt - 7'd1;
      end

      if (strb.stageWrite && grpInRange) stagedQ[grpIdx] <= memByte;
      if (strb.applyUpdate) activeQ <= stagedQ;

      if (strb.markAppend) appendQ <= 1'b1;
      if (strb.clrAppend)  appendQ <= 1'b0;
      if (strb.setErr) begin
        errQ    <= 1'b1;
        appendQ <= 1'b0;
      end
      if (strb.checkSum && memByte != sumQ) errQ <= 1'b1;
    end
  end

  // R9: the sequencer never pushes the store pointer past the array end
  a_r9_ptr_bound: assert property (@(posedge clk) disable iff (!rstN)
    memPtr <= MEM_LIMIT);

  // R7: active registers only move on an update strobe
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.applyUpdate |=> $stable(activeQ));

  // R6: a starting pass clears the error flag
  a_r6_err_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startStore || strb.startRestore) |=> !dataError);

  // R10: script buffer cannot be written during a pass
  a_r10_script_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn) |=> $stable(scriptQ));

endmodule

// File: rtl/snapshot_seq_ctrl.sv
module snapshot_seq_ctrl
  import snapshot_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  status_t stat,
  output strobe_t strb,
  output logic    busy
);

  state_e stateQ, stateD;
  logic   isDesc;

  assign busy   = (stateQ != ST_IDLE);
  assign isDesc = !stat.curByte[7];

  always_comb begin
    strb       = '0;
    strb.wrSel = SRC_SCRIPT;
    stateD     = stateQ;
    if (stateQ != ST_IDLE && stat.memFull) begin
      strb.setErr = 1'b1;
      stateD      = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          if (stat.cmdStore && stat.storeEn) begin
            strb.startStore = 1'b1;
            stateD          = ST_S_OP;
          end else if (stat.cmdRestore) begin
            strb.startRestore = 1'b1;
            stateD            = ST_R_OP;
          end
        end
        ST_S_OP: begin
          strb.memWrite = 1'b1;
          if (isDesc) begin
            strb.latchCnt  = 1'b1;
            strb.scriptAdv = 1'b1;
            stateD         = ST_S_HI;
          end else if (stat.curByte == OP_END) begin
            strb.scriptAdv = 1'b1;
            strb.clrAppend = 1'b1;
            stateD         = ST_S_SUM;
          end else if (stat.curByte == OP_PSEUDO) begin
            strb.markAppend = 1'b1;
            stateD          = ST_IDLE;
          end else begin
            strb.scriptAdv = 1'b1;
          end
        end
        ST_S_HI: begin
          strb.memWrite  = 1'b1;
          strb.latchHi   = 1'b1;
          strb.scriptAdv = 1'b1;
          stateD         = ST_S_LO;
        end
        ST_S_LO: begin
          strb.memWrite  = 1'b1;
          strb.latchLo   = 1'b1;
          strb.scriptAdv = 1'b1;
          stateD         = ST_S_DAT;
        end
        ST_S_DAT: begin
          strb.memWrite = 1'b1;
          strb.wrSel    = SRC_REG;
          strb.grpStep  = 1'b1;
          if (stat.cntZero) stateD = ST_S_OP;
        end
        ST_S_SUM: begin
          strb.memWrite = 1'b1;
          strb.wrSel    = SRC_SUM;
          stateD        = ST_IDLE;
        end
        ST_R_OP: begin
          strb.memRead = 1'b1;
          if (isDesc) begin
            strb.latchCnt = 1'b1;
            stateD        = ST_R_HI;
          end else if (stat.curByte == OP_END) begin
            stateD = ST_R_SUM;
          end else if (stat.curByte == OP_UPDATE) begin
            strb.applyUpdate = 1'b1;
          end
        end
        ST_R_HI: begin
          strb.memRead = 1'b1;
          strb.latchHi = 1'b1;
          stateD       = ST_R_LO;
        end
        ST_R_LO: begin
          strb.memRead = 1'b1;
          strb.latchLo = 1'b1;
          stateD       = ST_R_DAT;
        end
        ST_R_DAT: begin
          strb.memRead    = 1'b1;
          strb.stageWrite = 1'b1;
          strb.grpStep    = 1'b1;
          if (stat.cntZero) stateD = ST_R_OP;
        end
        ST_R_SUM: begin
          strb.checkSum = 1'b1;
          stateD        = ST_IDLE;
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R3: a store request without the enable leaves the sequencer idle
  a_r3_store_gated: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stat.cmdStore && !stat.storeEn && !stat.cmdRestore) |=> !busy);

  // R9: running out of storage ends the pass in the next cycle
  a_r9_full_ends: assert property (@(posedge clk) disable iff (!rstN)
    (busy && stat.memFull) |=> !busy);

  // R5: after the checksum slot the store pass is over
  a_r5_sum_ends: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_S_SUM) |=> !busy);

endmodule

// File: rtl/snapshot_seq.sv
module snapshot_seq
  import snapshot_seq_pkg::*;
#(
  parameter int REG_DEPTH    = 64,
  parameter int SCRIPT_DEPTH = 32,
  parameter int STORE_DEPTH  = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] regAddr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  output logic        busy,
  output logic        dataError
);

  strobe_t strb;
  status_t stat;

  snapshot_seq_ctrl ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .stat (stat),
    .strb (strb),
    .busy (busy)
  );

  snapshot_seq_dp #(
    .REG_DEPTH    (REG_DEPTH),
    .SCRIPT_DEPTH (SCRIPT_DEPTH),
    .STORE_DEPTH  (STORE_DEPTH)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .busy      (busy),
    .strb      (strb),
    .stat      (stat),
    .dataError (dataError)
  );

endmodule

// File: tb/snapshot_seq_tb.sv
`timescale 1ns/100ps
module snapshot_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        busy, dataError;

  int checks = 0;
  int failures = 0;

  localparam logic [15:0] SCR = 16'h0A00;
  localparam logic [15:0] ACT = 16'h0100;
  localparam logic [15:0] CMD = 16'h0B03;
  localparam logic [15:0] ENA = 16'h0B02;

  always #2.5 clk = ~clk;

  snapshot_seq dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .dataError(dataError)
  );

  task automatic checkEq(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%02h expected=0x%02h", tag, what, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic hostRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic expectReg(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] v;
    hostRead(a, v);
    checkEq(tag, $sformatf("reg 0x%04h", a), v, exp);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runPass(input logic [7:0] cmdBits);
    hostWrite(CMD, cmdBits);
    waitIdle();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // R1 reset state
  task automatic testReset();
    checkEq("R1", "busy", {7'd0, busy}, 8'h00);
    checkEq("R1", "dataError", {7'd0, dataError}, 8'h00);
    expectReg("R1", ENA, 8'h00);
    expectReg("R1", 16'h0005, 8'h00);
    expectReg("R1", ACT + 16'h0005, 8'h00);
    expectReg("R1", SCR, 8'h00);
  endtask

  // R2 address map
  task automatic testMap();
    hostWrite(16'h0003, 8'h3C);
    expectReg("R2", 16'h0003, 8'h3C);
    hostWrite(SCR + 16'h001F, 8'h5A);
    expectReg("R2", SCR + 16'h001F, 8'h5A);
    hostWrite(ACT + 16'h0003, 8'hEE);
    expectReg("R2", ACT + 16'h0003, 8'h00);
    expectReg("R2", 16'h0500, 8'h00);
    hostWrite(CMD, 8'h00);
    expectReg("R2", CMD, 8'h00);
    hostWrite(16'h0003, 8'h00);
  endtask

  // R3 store needs the enable
  task automatic testNoEnable();
    hostWrite(SCR + 0, 8'h00); hostWrite(SCR + 1, 8'h00);
    hostWrite(SCR + 2, 8'h05); hostWrite(SCR + 3, 8'hFF);
    hostWrite(CMD, 8'h01);
    checkEq("R3", "busy after store without enable", {7'd0, busy}, 8'h00);
    repeat (3) @(negedge clk);
    checkEq("R3", "busy stays low", {7'd0, busy}, 8'h00);
    hostWrite(ENA, 8'h01);
    expectReg("R2", ENA, 8'h01);
  endtask

  // R4 R5 R7 basic save and restore with update
  task automatic testBasic();
    hostWrite(16'h0005, 8'hAA); hostWrite(16'h0006, 8'hBB);
    hostWrite(16'h0007, 8'hCC); hostWrite(16'h0020, 8'h11);
    hostWrite(SCR + 0, 8'h02); hostWrite(SCR + 1, 8'h00); hostWrite(SCR + 2, 8'h05);
    hostWrite(SCR + 3, 8'h00); hostWrite(SCR + 4, 8'h00); hostWrite(SCR + 5, 8'h20);
    hostWrite(SCR + 6, 8'h80); hostWrite(SCR + 7, 8'hFF);
    hostWrite(CMD, 8'h01);
    checkEq("R3", "busy after accepted store", {7'd0, busy}, 8'h01);
    waitIdle();
    checkEq("R5", "dataError after store", {7'd0, dataError}, 8'h00);
    hostWrite(16'h0005, 8'h00); hostWrite(16'h0006, 8'h00);
    hostWrite(16'h0007, 8'h00); hostWrite(16'h0020, 8'h00);
    hostWrite(16'h0008, 8'h77);
    runPass(8'h02);
    expectReg("R4", 16'h0005, 8'hAA);
    expectReg("R4", 16'h0006, 8'hBB);
    expectReg("R4", 16'h0007, 8'hCC);
    expectReg("R4", 16'h0020, 8'h11);
    expectReg("R4", 16'h0008, 8'h77);
    expectReg("R7", ACT + 16'h0005, 8'hAA);
    expectReg("R7", ACT + 16'h0020, 8'h11);
    expectReg("R7", ACT + 16'h0008, 8'h77);
    checkEq("R5", "dataError after restore", {7'd0, dataError}, 8'h00);
  endtask

  // R7 restore without an update code leaves active alone
  task automatic testNoUpdate();
    hostWrite(16'h0005, 8'h55);
    hostWrite(SCR + 0, 8'h00); hostWrite(SCR + 1, 8'h00);
    hostWrite(SCR + 2, 8'h05); hostWrite(SCR + 3, 8'hFF);
    runPass(8'h01);
    hostWrite(16'h0005, 8'h66);
    runPass(8'h02);
    expectReg("R7", 16'h0005, 8'h55);
    expectReg("R7", ACT + 16'h0005, 8'hAA);
  endtask

  // R8 pseudo-end followed by an appending store
  task automatic testAppend();
    hostWrite(16'h0008, 8'h81);
    hostWrite(SCR + 0, 8'h00); hostWrite(SCR + 1, 8'h00);
    hostWrite(SCR + 2, 8'h08); hostWrite(SCR + 3, 8'hFE);
    runPass(8'h01);
    checkEq("R8", "busy after pseudo-end", {7'd0, busy}, 8'h00);
    hostWrite(16'h0009, 8'h92);
    hostWrite(SCR + 0, 8'h00); hostWrite(SCR + 1, 8'h00); hostWrite(SCR + 2, 8'h09);
    hostWrite(SCR + 3, 8'h80); hostWrite(SCR + 4, 8'hFF);
    runPass(8'h01);
    hostWrite(16'h0008, 8'h00); hostWrite(16'h0009, 8'h00);
    runPass(8'h02);
    expectReg("R8", 16'h0008, 8'h81);
    expectReg("R8", 16'h0009, 8'h92);
    expectReg("R8", ACT + 16'h0008, 8'h81);
    expectReg("R8", ACT + 16'h0009, 8'h92);
    checkEq("R8", "dataError after appended image", {7'd0, dataError}, 8'h00);
  endtask

  // R6 R8 truncated image runs into stale tail and mismatches
  task automatic testBadSum();
    hostWrite(16'h0005, 8'h10); hostWrite(16'h0006, 8'h30);
    hostWrite(SCR + 0, 8'h00); hostWrite(SCR + 1, 8'h00); hostWrite(SCR + 2, 8'h05);
    hostWrite(SCR + 3, 8'h80);
    hostWrite(SCR + 4, 8'h00); hostWrite(SCR + 5, 8'h00); hostWrite(SCR + 6, 8'h06);
    hostWrite(SCR + 7, 8'hFF);
    runPass(8'h01);
    hostWrite(16'h0005, 8'h20);
    hostWrite(SCR + 3, 8'hFE);
    runPass(8'h01);
    hostWrite(16'h0006, 8'h00);
    runPass(8'h02);
    expectReg("R8", 16'h0005, 8'h20);
    expectReg("R8", 16'h0006, 8'h30);
    checkEq("R6", "dataError on mismatch", {7'd0, dataError}, 8'h01);
    expectReg("R6", 16'h0B01, 8'h01);
  endtask

  // R6 R8 next pass clears error and restarts the image
  task automatic testRecover();
    hostWrite(SCR + 0, 8'h00); hostWrite(SCR + 1, 8'h00);
    hostWrite(SCR + 2, 8'h05); hostWrite(SCR + 3, 8'hFF);
    runPass(8'h01);
    checkEq("R6", "dataError cleared by store", {7'd0, dataError}, 8'h00);
    hostWrite(16'h0005, 8'h00);
    runPass(8'h02);
    expectReg("R8", 16'h0005, 8'h20);
    checkEq("R6", "dataError after clean restore", {7'd0, dataError}, 8'h00);
  endtask

  // R9 R10 oversize group exhausts the store; writes during the pass dropped
  task automatic testOverflow();
    hostWrite(SCR + 0, 8'h7F); hostWrite(SCR + 1, 8'h00);
    hostWrite(SCR + 2, 8'h00); hostWrite(SCR + 3, 8'hFF);
    hostWrite(CMD, 8'h01);
    hostWrite(16'h0030, 8'h99);
    hostWrite(SCR + 0, 8'h12);
    hostWrite(ENA, 8'h00);
    checkEq("R9", "busy during long pass", {7'd0, busy}, 8'h01);
    waitIdle();
    checkEq("R9", "dataError on exhausted store", {7'd0, dataError}, 8'h01);
    expectReg("R10", 16'h0030, 8'h00);
    expectReg("R10", SCR, 8'h7F);
    expectReg("R10", ENA, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMap();
    testNoEnable();
    testBasic();
    testNoUpdate();
    testAppend();
    testBadSum();
    testRecover();
    testOverflow();
    finishRun();
  end

endmodule